// File: doc/BRIEF.md
# Dual-Thread Multiported Register File

This block stores the architectural integer registers for two hardware threads. Every register has one copy per thread. One thread is active, chosen by a select input. Many read ports return the active thread's copies in the same cycle. A larger group of write ports updates the active copies. A smaller group of write ports updates the other thread's copies in the same cycle. Because the two groups touch different thread copies, they never conflict.

Each stored entry is 65 bits: 64 data bits and one even-parity bit. The block computes the parity bit when it stores a word, and it returns the bit with every read. The general set has 128 registers. A separate set of 16 kernel registers can be overlaid on architectural indices 16 to 31 while a kernel-mode input is high. Storage is split into banks of 16 entries, and the upper bits of the physical index select the bank. The bank count is 8 for the general set plus 1 for the kernel set.

A read of a register that an active port writes in the same cycle returns the new data through a bypass at the read output. Register 0 is hard-wired to zero. In the cycle in which the thread select changes value, every write is dropped.

Top module: `dtrf_top`

## Requirements
- R1: A read of index 0 returns all 65 bits zero. A write to index 0 is discarded and does not show up in the same cycle or in any later cycle.
- R2: Reads are combinational. A read returns the active thread's stored copy. A write made at a clock edge is returned from the next cycle on.
- R3: Active-group writes (ports wa) update the active thread's copy. Inactive-group writes (ports wi) update the other thread's copy. Both may target the same index in the same cycle, and each write lands in its own thread copy.
- R4: When several active ports write the same register in one cycle, the highest-numbered port's data is stored. The inactive group resolves the same way among its own ports.
- R5: A read of a register that an enabled active port writes in the same cycle returns that port's write data, with its parity. If several ports hit the register, the highest-numbered port wins.
- R6: With `kmode` = 1, indices 16 to 31 select the 16 kernel registers. With `kmode` = 0, they select general registers 16 to 31. The two sets are separate storage. `kmode` applies to reads and to both write groups.
- R7: A thread-switch cycle is a cycle in which `thr_sel` differs from its value at the previous clock edge. That previous value is 0 after reset. In a thread-switch cycle every write from both groups is discarded and no bypass is applied.
- R8: Bit 64 of each read result equals the XOR of bits 63:0.
- R9: Reset (`rst_n` low at a clock edge) clears every entry of both threads to zero.
- R10: An inactive-group write is never visible to reads while its thread stays inactive. This holds in the same cycle and in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| thr_sel | input | 1 | Active thread number |
| kmode | input | 1 | Overlay kernel registers on indices 16 to 31 |
| rd_idx | input | N_RD x 7 | Read index per read port |
| rd_data | output | N_RD x 65 | Read result per port: parity in bit 64, data in bits 63:0 |
| wa_en | input | N_WA | Write enable per active-group port |
| wa_idx | input | N_WA x 7 | Write index per active-group port |
| wa_data | input | N_WA x 64 | Write data per active-group port |
| wi_en | input | N_WI | Write enable per inactive-group port |
| wi_idx | input | N_WI x 7 | Write index per inactive-group port |
| wi_data | input | N_WI x 64 | Write data per inactive-group port |

## Verification
Read results, including bypassed data, are due in the same cycle as the indices that request them. A write that is stored becomes visible one rising edge later. A write dropped in a switch cycle never becomes visible. The bench changes inputs 1 ns after a rising edge and pushes the expected value of every read port for that cycle. It updates its reference state at the following rising edge. The monitor compares the outputs at the falling edge in between, so each expectation is checked exactly in the cycle it is due.

// File: rtl/dtrf_pkg.sv
// Package dtrf_pkg
// Shared thread type and helpers for the dual-thread register file.
// Assumes exactly two hardware threads, named by a single bit.
package dtrf_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NUM_THREADS = 2;

    typedef logic thr_t;

    // Returns the thread that is not the given one.
    function automatic thr_t peer_thr(thr_t t);
        return ~t;
    endfunction
endpackage

// File: rtl/rf_idx_map.sv
// Module rf_idx_map
// Turns an architectural register index into a physical entry number.
// When kernel mode is set and the index falls in the overlay window, the
// result points into the kernel set placed after the general registers.
// Assumes that the window lies inside the general index range.
module rf_idx_map #(
    parameter int NUM_GR  = 128,
    parameter int NUM_KR  = 16,
    parameter int KR_BASE = 16,
    parameter int IDX_W   = 7,
    parameter int PHYS_W  = 8
) (
    input  logic [IDX_W-1:0]  arch,
    input  logic              kmode,
    output logic [PHYS_W-1:0] phys
);
    timeunit 1ns;
    timeprecision 1ps;

    logic in_win;

    // Detects whether the index lies in the overlay window.
    always_comb begin
        in_win = (arch >= IDX_W'(KR_BASE)) && (arch < IDX_W'(KR_BASE + NUM_KR));
    end

    // Selects the kernel slot or the general slot.
    always_comb begin
        if (kmode && in_win) begin
            phys = PHYS_W'(NUM_GR) + PHYS_W'(arch - IDX_W'(KR_BASE));
        end else begin
            phys = PHYS_W'(arch);
        end
    end
endmodule

// File: rtl/rf_bank.sv
// Module rf_bank
// Holds BANK_REGS physical entries with one copy per thread.
// Active-group writes go to the active copy and inactive-group writes go
// to the peer copy. Within a group the highest-numbered port wins. Parity
// is generated on the way in. Physical entry 0 is never written. Assumes
// that port indices are already mapped to physical entries.
module rf_bank
    import dtrf_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int BANK_REGS = 16,
    parameter int BANK_ID   = 0,
    parameter int PHYS_W    = 8,
    parameter int N_WA      = 8,
    parameter int N_WI      = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  thr_t                                act_thr,
    input  logic                                wr_block,
    input  logic [N_WA-1:0]                     wa_en,
    input  logic [N_WA-1:0][PHYS_W-1:0]         wa_phys,
    input  logic [N_WA-1:0][DATA_W-1:0]         wa_data,
    input  logic [N_WI-1:0]                     wi_en,
    input  logic [N_WI-1:0][PHYS_W-1:0]         wi_phys,
    input  logic [N_WI-1:0][DATA_W-1:0]         wi_data,
    output logic [BANK_REGS-1:0][DATA_W:0]      q_act
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BASE = BANK_ID * BANK_REGS;

    logic [NUM_THREADS-1:0][BANK_REGS-1:0][DATA_W:0] mem;
    thr_t                                            pas_thr;

    // Names the thread that the inactive group writes.
    always_comb begin
        pas_thr = peer_thr(act_thr);
    end

    // Stores the words of both groups, later ports overriding earlier ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (!wr_block) begin
            for (int e = 0; e < BANK_REGS; e++) begin
                if ((BASE + e) != 0) begin
                    for (int j = 0; j < N_WA; j++) begin
                        if (wa_en[j] && (wa_phys[j] == PHYS_W'(BASE + e))) begin
                            mem[act_thr][e] <= {^wa_data[j], wa_data[j]};
                        end
                    end
                    for (int k = 0; k < N_WI; k++) begin
                        if (wi_en[k] && (wi_phys[k] == PHYS_W'(BASE + e))) begin
                            mem[pas_thr][e] <= {^wi_data[k], wi_data[k]};
                        end
                    end
                end
            end
        end
    end

    // Presents the active thread's copies to the read side.
    always_comb begin
        for (int e = 0; e < BANK_REGS; e++) begin
            q_act[e] = mem[act_thr][e];
        end
    end
endmodule

// File: rtl/rf_read_port.sv
// Module rf_read_port
// One read port. It picks the active copy of the addressed entry and then
// applies the same-cycle bypass from the active write group, letting the
// highest-numbered matching port win. Architectural index 0 is forced to
// zero. Assumes that byp_ok is low in thread-switch cycles.
module rf_read_port #(
    parameter int DATA_W   = 64,
    parameter int NUM_PHYS = 144,
    parameter int IDX_W    = 7,
    parameter int PHYS_W   = 8,
    parameter int N_WA     = 8
) (
    input  logic [IDX_W-1:0]                arch,
    input  logic [PHYS_W-1:0]               phys,
    input  logic [NUM_PHYS-1:0][DATA_W:0]   act_words,
    input  logic                            byp_ok,
    input  logic [N_WA-1:0]                 wa_en,
    input  logic [N_WA-1:0][PHYS_W-1:0]     wa_phys,
    input  logic [N_WA-1:0][DATA_W-1:0]     wa_data,
    output logic [DATA_W:0]                 rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    // Stored word, then bypass in port order, then the zero register.
    always_comb begin
        rd_data = act_words[phys];
        if (byp_ok) begin
            for (int j = 0; j < N_WA; j++) begin
                if (wa_en[j] && (wa_phys[j] == phys)) begin
                    rd_data = {^wa_data[j], wa_data[j]};
                end
            end
        end
        if (arch == '0) begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/dtrf_top.sv
// Module dtrf_top
// Dual-thread register file with an active and an inactive write group,
// a kernel-register overlay, a read bypass and stored parity. A change of
// thr_sel blocks every write for that cycle. Assumes that
// NUM_GR + NUM_KR is a multiple of BANK_REGS.
module dtrf_top
    import dtrf_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int NUM_GR    = 128,
    parameter int NUM_KR    = 16,
    parameter int KR_BASE   = 16,
    parameter int BANK_REGS = 16,
    parameter int N_RD      = 12,
    parameter int N_WA      = 8,
    parameter int N_WI      = 2,
    localparam int IDX_W    = $clog2(NUM_GR)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           thr_sel,
    input  logic                           kmode,
    input  logic [N_RD-1:0][IDX_W-1:0]     rd_idx,
    output logic [N_RD-1:0][DATA_W:0]      rd_data,
    input  logic [N_WA-1:0]                wa_en,
    input  logic [N_WA-1:0][IDX_W-1:0]     wa_idx,
    input  logic [N_WA-1:0][DATA_W-1:0]    wa_data,
    input  logic [N_WI-1:0]                wi_en,
    input  logic [N_WI-1:0][IDX_W-1:0]     wi_idx,
    input  logic [N_WI-1:0][DATA_W-1:0]    wi_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NUM_PHYS = NUM_GR + NUM_KR;
    localparam int PHYS_W   = $clog2(NUM_PHYS);
    localparam int NBANK    = NUM_PHYS / BANK_REGS;

    thr_t                                       prev_thr;
    logic                                       wr_block;
    logic [N_RD-1:0][PHYS_W-1:0]                rd_phys;
    logic [N_WA-1:0][PHYS_W-1:0]                wa_phys;
    logic [N_WI-1:0][PHYS_W-1:0]                wi_phys;
    logic [NBANK-1:0][BANK_REGS-1:0][DATA_W:0]  bank_q;
    logic [NUM_PHYS-1:0][DATA_W:0]              act_words;

    // Remembers the thread select of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_thr <= 1'b0;
        end else begin
            prev_thr <= thr_sel;
        end
    end

    // Flags a thread-switch cycle, which blocks writes and bypass.
    always_comb begin
        wr_block = (thr_sel != prev_thr);
    end

    // Maps the read indices.
    for (genvar i = 0; i < N_RD; i++) begin : g_rmap
        rf_idx_map #(
            .NUM_GR(NUM_GR), .NUM_KR(NUM_KR), .KR_BASE(KR_BASE),
            .IDX_W(IDX_W), .PHYS_W(PHYS_W)
        ) u_map (
            .arch(rd_idx[i]), .kmode(kmode), .phys(rd_phys[i])
        );
    end

    // Maps the active-group write indices.
    for (genvar j = 0; j < N_WA; j++) begin : g_amap
        rf_idx_map #(
            .NUM_GR(NUM_GR), .NUM_KR(NUM_KR), .KR_BASE(KR_BASE),
            .IDX_W(IDX_W), .PHYS_W(PHYS_W)
        ) u_map (
            .arch(wa_idx[j]), .kmode(kmode), .phys(wa_phys[j])
        );
    end

    // Maps the inactive-group write indices.
    for (genvar k = 0; k < N_WI; k++) begin : g_imap
        rf_idx_map #(
            .NUM_GR(NUM_GR), .NUM_KR(NUM_KR), .KR_BASE(KR_BASE),
            .IDX_W(IDX_W), .PHYS_W(PHYS_W)
        ) u_map (
            .arch(wi_idx[k]), .kmode(kmode), .phys(wi_phys[k])
        );
    end

    // Storage banks: the general banks first, then the kernel bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rf_bank #(
            .DATA_W(DATA_W), .BANK_REGS(BANK_REGS), .BANK_ID(b),
            .PHYS_W(PHYS_W), .N_WA(N_WA), .N_WI(N_WI)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .act_thr(thr_sel), .wr_block(wr_block),
            .wa_en(wa_en), .wa_phys(wa_phys), .wa_data(wa_data),
            .wi_en(wi_en), .wi_phys(wi_phys), .wi_data(wi_data),
            .q_act(bank_q[b])
        );
    end

    // Flattens the bank outputs into a single array of physical entries.
    always_comb begin
        act_words = bank_q;
    end

    // Read ports with bypass.
    for (genvar i = 0; i < N_RD; i++) begin : g_rd
        rf_read_port #(
            .DATA_W(DATA_W), .NUM_PHYS(NUM_PHYS), .IDX_W(IDX_W),
            .PHYS_W(PHYS_W), .N_WA(N_WA)
        ) u_rd (
            .arch(rd_idx[i]), .phys(rd_phys[i]), .act_words(act_words),
            .byp_ok(!wr_block), .wa_en(wa_en), .wa_phys(wa_phys),
            .wa_data(wa_data), .rd_data(rd_data[i])
        );
    end
endmodule

// File: rtl/dtrf_chk.sv
// Module dtrf_chk
// Assertion checker bound to dtrf_top. It keeps its own record of the
// previous thread select and enables its checks two cycles after reset, so
// that no check sees values from before the first clock edge.
module dtrf_chk #(
    parameter int DATA_W = 64,
    parameter int N_RD   = 12,
    parameter int IDX_W  = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        thr_sel,
    input  logic                        kmode,
    input  logic [N_RD-1:0][IDX_W-1:0]  rd_idx,
    input  logic [N_RD-1:0][DATA_W:0]   rd_data,
    input  logic                        top_en,
    input  logic [IDX_W-1:0]            top_idx,
    input  logic [DATA_W-1:0]           top_data,
    input  logic                        any_wr
);
    timeunit 1ns;
    timeprecision 1ps;

    logic       c_prev;
    logic [1:0] arm;
    logic       sw;
    logic       live;

    // Tracks the previous thread select and the arming delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_prev <= 1'b0;
            arm    <= 2'b00;
        end else begin
            c_prev <= thr_sel;
            arm    <= {arm[0], 1'b1};
        end
    end

    // Derives the switch-cycle flag and the enable for the checks.
    always_comb begin
        sw   = (thr_sel != c_prev);
        live = arm[1];
    end

    for (genvar i = 0; i < N_RD; i++) begin : g_port
        // R1: index 0 reads zero
        a_r1_zero_reg: assert property (@(posedge clk) disable iff (!rst_n || !live)
            (rd_idx[i] == '0) |-> (rd_data[i] == '0));

        // R8: bit 64 carries the even parity of the data bits
        a_r8_parity: assert property (@(posedge clk) disable iff (!rst_n || !live)
            rd_data[i][DATA_W] == ^rd_data[i][DATA_W-1:0]);

        // R5: the highest active port always wins the bypass
        a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n || !live)
            (!sw && top_en && (top_idx == rd_idx[i]) && (rd_idx[i] != '0))
            |-> (rd_data[i][DATA_W-1:0] == top_data));
    end

    // R7: writes in a switch cycle leave the read result unchanged next cycle
    a_r7_switch_block: assert property (@(posedge clk) disable iff (!rst_n || !live)
        ($past(sw) && !sw && $stable(rd_idx[0]) && $stable(kmode) && !any_wr)
        |-> (rd_data[0] == $past(rd_data[0])));
endmodule

bind dtrf_top dtrf_chk #(
    .DATA_W(DATA_W), .N_RD(N_RD), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .kmode(kmode),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .top_en(wa_en[N_WA-1]), .top_idx(wa_idx[N_WA-1]),
    .top_data(wa_data[N_WA-1]), .any_wr(|wa_en)
);

// File: tb/dtrf_top_tb.sv
// Scoreboard bench for dtrf_top. A driver task pushes the expected value of
// every read port for the current cycle. A monitor pops the queue at the
// falling edge and compares. The expected values come from a model of the
// requirements that the bench keeps itself.
module dtrf_top_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NR = 12;
    localparam int NA = 8;
    localparam int NI = 2;

    typedef struct {
        int          port;
        logic [64:0] exp;
        string       req;
    } item_t;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    thr_sel;
    logic                    kmode;
    logic [NR-1:0][6:0]      rd_idx;
    logic [NR-1:0][64:0]     rd_data;
    logic [NA-1:0]           wa_en;
    logic [NA-1:0][6:0]      wa_idx;
    logic [NA-1:0][63:0]     wa_data;
    logic [NI-1:0]           wi_en;
    logic [NI-1:0][6:0]      wi_idx;
    logic [NI-1:0][63:0]     wi_data;

    item_t       sb[$];
    logic [63:0] mdl [2][144];
    logic        mprev;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    always #4 clk = ~clk;

    dtrf_top u_dut (
        .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .kmode(kmode),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
        .wi_en(wi_en), .wi_idx(wi_idx), .wi_data(wi_data)
    );

    function automatic int phys_of(logic [6:0] a, logic k);
        if (k && a >= 7'd16 && a < 7'd32) return 128 + int'(a) - 16;
        return int'(a);
    endfunction

    function automatic logic [64:0] exp_rd(int i);
        logic [63:0] v;
        int          p;
        int          t;
        if (rd_idx[i] == 7'd0) return '0;
        p = phys_of(rd_idx[i], kmode);
        t = thr_sel ? 1 : 0;
        v = mdl[t][p];
        if (thr_sel == mprev) begin
            for (int j = 0; j < NA; j++)
                if (wa_en[j] && phys_of(wa_idx[j], kmode) == p) v = wa_data[j];
        end
        return {^v, v};
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 2; t++)
            for (int p = 0; p < 144; p++) mdl[t][p] = '0;
        mprev = 1'b0;
    endtask

    task automatic model_commit();
        int t;
        int p;
        t = thr_sel ? 1 : 0;
        if (thr_sel == mprev) begin
            for (int j = 0; j < NA; j++) begin
                p = phys_of(wa_idx[j], kmode);
                if (wa_en[j] && p != 0) mdl[t][p] = wa_data[j];
            end
            for (int k = 0; k < NI; k++) begin
                p = phys_of(wi_idx[k], kmode);
                if (wi_en[k] && p != 0) mdl[1-t][p] = wi_data[k];
            end
        end
        mprev = thr_sel;
    endtask

    // Driver: pushes the expectations for this cycle, then commits at the edge.
    task automatic step(string req);
        for (int i = 0; i < NR; i++) begin
            item_t it;
            it.port = i;
            it.exp  = exp_rd(i);
            it.req  = req;
            sb.push_back(it);
        end
        @(posedge clk);
        model_commit();
        #1;
    endtask

    task automatic clr_wr();
        wa_en = '0;
        wi_en = '0;
    endtask

    task automatic rd_all(logic [6:0] a);
        for (int i = 0; i < NR; i++) rd_idx[i] = a;
    endtask

    // Monitor: compares every queued item at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (rd_data[it.port] !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s port %0d: got %h expected %h",
                             it.req, it.port, rd_data[it.port], it.exp);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; thr_sel = 1'b0; kmode = 1'b0;
        rd_idx = '0; wa_en = '0; wa_idx = '0; wa_data = '0;
        wi_en = '0; wi_idx = '0; wi_data = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: every entry reads zero after reset
        for (int i = 0; i < NR; i++) rd_idx[i] = 7'(i * 9 + 1);
        step("R9");

        // R5: same-cycle bypass on eight different registers
        for (int j = 0; j < NA; j++) begin
            wa_en[j] = 1'b1; wa_idx[j] = 7'(j + 1);
            wa_data[j] = {$urandom, $urandom};
        end
        for (int i = 0; i < NR; i++) rd_idx[i] = 7'(i % 8 + 1);
        step("R5");
        clr_wr();
        step("R2");

        // R1: a write to index 0 is discarded
        wa_en[3] = 1'b1; wa_idx[3] = 7'd0; wa_data[3] = 64'hFFFF_0000_1234_5678;
        rd_all(7'd0);
        step("R1");
        clr_wr();
        step("R1");

        // R4: all active ports hit index 40, the highest port wins
        for (int j = 0; j < NA; j++) begin
            wa_en[j] = 1'b1; wa_idx[j] = 7'd40;
            wa_data[j] = 64'h1111_0000_0000_0000 * 64'(j + 1);
        end
        rd_all(7'd40);
        step("R4");
        clr_wr();
        step("R4");

        // R6: kernel overlay keeps separate storage
        kmode = 1'b1; wa_en[0] = 1'b1; wa_idx[0] = 7'd20;
        wa_data[0] = 64'hCAFE_F00D_0000_0001;
        rd_all(7'd20);
        step("R6");
        clr_wr(); kmode = 1'b0;
        step("R6");
        kmode = 1'b1;
        step("R6");
        kmode = 1'b0; wa_en[0] = 1'b1; wa_data[0] = 64'h0BAD_BEEF_0000_0002;
        step("R6");
        clr_wr(); kmode = 1'b1;
        step("R6");
        kmode = 1'b0;

        // R3: the two groups write index 50 in the same cycle
        wi_en[0] = 1'b1; wi_idx[0] = 7'd50; wi_data[0] = 64'h0000_0000_C0C0_C0C0;
        wa_en[1] = 1'b1; wa_idx[1] = 7'd50; wa_data[1] = 64'h0000_0000_D0D0_D0D0;
        rd_all(7'd50);
        step("R3");
        clr_wr();
        step("R10");
        // R10: an inactive write stays hidden in the same cycle and later
        wi_en[1] = 1'b1; wi_idx[1] = 7'd50; wi_data[1] = 64'h0000_0000_E0E0_E0E0;
        step("R10");
        clr_wr();
        step("R10");

        // R7: the switch cycle drops writes from both groups and skips bypass
        thr_sel = 1'b1;
        wa_en[2] = 1'b1; wa_idx[2] = 7'd50; wa_data[2] = 64'h0000_0000_F0F0_F0F0;
        wi_en[0] = 1'b1; wi_idx[0] = 7'd50; wi_data[0] = 64'h0000_0000_9999_9999;
        step("R7");
        clr_wr();
        step("R7");
        step("R3");
        thr_sel = 1'b0;
        step("R7");
        step("R3");

        // R8: parity over several data patterns
        wa_en[0] = 1'b1; wa_idx[0] = 7'd70; wa_data[0] = '1;
        wa_en[1] = 1'b1; wa_idx[1] = 7'd71; wa_data[1] = 64'h1;
        wa_en[2] = 1'b1; wa_idx[2] = 7'd72; wa_data[2] = 64'h8000_0000_0000_0003;
        for (int i = 0; i < NR; i++) rd_idx[i] = 7'(70 + i % 3);
        step("R8");
        clr_wr();
        step("R8");

        // R2: mixed random traffic
        for (int c = 0; c < 400; c++) begin
            if ($urandom_range(15) == 0) thr_sel = ~thr_sel;
            kmode = ($urandom_range(3) == 0);
            for (int j = 0; j < NA; j++) begin
                wa_en[j] = $urandom_range(1);
                wa_idx[j] = 7'($urandom_range(63));
                wa_data[j] = {$urandom, $urandom};
            end
            for (int k = 0; k < NI; k++) begin
                wi_en[k] = $urandom_range(1);
                wi_idx[k] = 7'($urandom_range(63));
                wi_data[k] = {$urandom, $urandom};
            end
            for (int i = 0; i < NR; i++) rd_idx[i] = 7'($urandom_range(63));
            step("R2");
        end
        clr_wr();
        step("R2");

        @(negedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule